// File: doc/BRIEF.md
# Windowed Frame Buffer Word Address Generator

This block produces the stream of 32-bit word read addresses that a display fetch engine uses to pull a visible window out of a larger frame buffer in memory. Each line of the window is a run of consecutive words. In two-dimensional mode, a programmable skip is added after the last word of every line, so the window can sit anywhere inside a wider image. A sub-word pixel offset is passed to the downstream pixel unpacker at the start of every line. With two-dimensional mode off, the skip and the offset are ignored and the frame is read as one contiguous run.

Addresses leave through a request/acknowledge pair. The request stays high while fetching is enabled. The address is held until it is acknowledged, and each acknowledge moves it to the next word. The address output also serves as the frame pointer the host reads to judge how much of the frame remains.

Base addresses are double buffered. Host writes land in shadow registers, and the active pointers change only at an end of frame, so the host can fill a back buffer while the front buffer is shown. In dual-panel mode each frame fetches the upper-half window from pointer 0 and then the lower-half window from pointer 1. Both pointers are committed together at the next frame boundary, but only after the host has set an update-validate flag. That flag clears itself once the commit has happened.

Top module: `wfb_addr_gen`

## Requirements
- R1: After reset, `req`, `eof` and `upd_pending` are 0 and `fetch_addr` is 0. All active and shadow base pointers are zero.
- R2: `req` is 1 only in the cycle after a cycle with `cfg_en` high. Dropping `cfg_en` abandons the frame, and fetching resumes at the first word of the active pointer 0.
- R3: While `req` is high and `ack` is low, `fetch_addr` is held. Each acknowledged word that is not the last of its line advances `fetch_addr` by 4. Bits [1:0] of `fetch_addr` are always 0.
- R4: With `cfg_2d`=1, the address after the last word of a line is that word's address + 4 + 4*`cfg_skip`.
- R5: `line_start` is 1 exactly while the word of index 0 of a line is offered. `line_off` equals `cfg_pix_off` when `cfg_2d`=1 and 0 otherwise.
- R6: With `cfg_2d`=0, `cfg_skip` is ignored and the next line starts at the last word + 4.
- R7: One cycle after the last word of the last line of the last panel is acknowledged, `eof` is high for one cycle. At that point `fetch_addr` holds the newly committed pointer 0.
- R8: In single-panel mode (`cfg_dual`=0), a write to pointer 0 has no effect on the frame in progress. It becomes active at the next end of frame.
- R9: In dual-panel mode, a frame is `cfg_lines_m1`+1 lines from pointer 0 (`panel`=0), then the same geometry from pointer 1 (`panel`=1). `eof` follows only the second half.
- R10: In dual-panel mode, the shadow pointers become active at an end of frame only if `upd_pending` is 1 there. Both change together and `upd_pending` returns to 0. Without the flag, the old pointers are kept.
- R11: A pointer write or an `upd_valid` pulse in the same cycle as the final acknowledge of a frame applies to the following frame. `upd_pending` stays 1 after that end of frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | Fetch enable |
| cfg_2d | input | 1 | Window (2D) addressing enable |
| cfg_dual | input | 1 | Two panel halves per frame |
| cfg_pix_off | input | OW | First-pixel position inside the first word |
| cfg_skip | input | IW | Line-to-line skip in words |
| cfg_words_m1 | input | LW | Words per line minus one |
| cfg_lines_m1 | input | NW | Lines per panel minus one |
| base0_wr | input | 1 | Write strobe, shadow pointer 0 |
| base0_wdata | input | AW | Byte address for pointer 0 (bits [1:0] dropped) |
| base1_wr | input | 1 | Write strobe, shadow pointer 1 |
| base1_wdata | input | AW | Byte address for pointer 1 (bits [1:0] dropped) |
| upd_valid | input | 1 | Pulse: validate both shadow pointers |
| ack | input | 1 | Word accepted |
| req | output | 1 | Word request |
| fetch_addr | output | AW | Current word address / frame pointer |
| line_start | output | 1 | Offered word is first of a line |
| line_off | output | OW | Pixel offset for the line start |
| panel | output | 1 | Panel half being fetched |
| eof | output | 1 | End-of-frame pulse |
| upd_pending | output | 1 | Validate flag awaiting a frame boundary |

## Verification
Two events can land in the same cycle: the final acknowledge of a frame, which commits the pointers, and a host update, meaning a shadow pointer write or an `upd_valid` pulse. The bench drives both pointer writes and the validate pulse in the very cycle it gives the last acknowledge of a dual-panel frame. It then checks three things. The pointer presented right after `eof` is still the old one. `upd_pending` is still set. The frame after that starts from the new pointers.

// File: rtl/wfb_addr_gen.sv
module wfb_addr_gen #(
  parameter int AW = 32,
  parameter int LW = 12,
  parameter int NW = 12,
  parameter int OW = 5,
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_en,
  input  logic          cfg_2d,
  input  logic          cfg_dual,
  input  logic [OW-1:0] cfg_pix_off,
  input  logic [IW-1:0] cfg_skip,
  input  logic [LW-1:0] cfg_words_m1,
  input  logic [NW-1:0] cfg_lines_m1,
  input  logic          base0_wr,
  input  logic [AW-1:0] base0_wdata,
  input  logic          base1_wr,
  input  logic [AW-1:0] base1_wdata,
  input  logic          upd_valid,
  input  logic          ack,
  output logic          req,
  output logic [AW-1:0] fetch_addr,
  output logic          line_start,
  output logic [OW-1:0] line_off,
  output logic          panel,
  output logic          eof,
  output logic          upd_pending
);
  localparam int PADW = AW - IW - 2;
  localparam logic [AW-1:0] WSTEP = AW'(4);
  localparam logic [AW-1:0] AMASK = ~AW'(3);

  logic [AW-1:0] act0, act1, sh0, sh1, addr;
  logic [LW-1:0] wcnt;
  logic [NW-1:0] lcnt;
  logic          pan, pend, req_q, eof_q;

  wire fire      = cfg_en & req_q & ack;
  wire last_w    = (wcnt == cfg_words_m1);
  wire last_l    = (lcnt == cfg_lines_m1);
  wire last_p    = ~cfg_dual | pan;
  wire frame_end = fire & last_w & last_l & last_p;

  wire [AW-1:0] skip_b = cfg_2d ? {{PADW{1'b0}}, cfg_skip, 2'b00} : '0;
  wire [AW-1:0] nxt0   = (cfg_dual & ~pend) ? act0 : sh0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh0 <= '0;
      sh1 <= '0;
    end else begin
      if (base0_wr) sh0 <= base0_wdata & AMASK;
      if (base1_wr) sh1 <= base1_wdata & AMASK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act0 <= '0;
      act1 <= '0;
      pend <= 1'b0;
    end else if (frame_end && cfg_dual) begin
      if (pend) begin
        act0 <= sh0;
        act1 <= sh1;
      end
      pend <= upd_valid;
    end else begin
      if (frame_end) act0 <= sh0;
      if (upd_valid) pend <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      eof_q <= 1'b0;
    end else begin
      req_q <= cfg_en;
      eof_q <= frame_end;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
      wcnt <= '0;
      lcnt <= '0;
      pan  <= 1'b0;
    end else if (!cfg_en) begin
      addr <= act0;
      wcnt <= '0;
      lcnt <= '0;
      pan  <= 1'b0;
    end else if (fire) begin
      if (!last_w) begin
        addr <= addr + WSTEP;
        wcnt <= wcnt + 1'b1;
      end else if (!last_l) begin
        addr <= addr + WSTEP + skip_b;
        wcnt <= '0;
        lcnt <= lcnt + 1'b1;
      end else if (!last_p) begin
        addr <= act1;
        wcnt <= '0;
        lcnt <= '0;
        pan  <= 1'b1;
      end else begin
        addr <= nxt0;
        wcnt <= '0;
        lcnt <= '0;
        pan  <= 1'b0;
      end
    end
  end

  assign req         = req_q;
  assign fetch_addr  = addr;
  assign line_start  = req_q & (wcnt == '0);
  assign line_off    = cfg_2d ? cfg_pix_off : '0;
  assign panel       = pan;
  assign eof         = eof_q;
  assign upd_pending = pend;
endmodule

// File: rtl/wfb_addr_gen_chk.sv
module wfb_addr_gen_chk #(
  parameter int AW = 32,
  parameter int LW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_en,
  input logic          cfg_dual,
  input logic [LW-1:0] cfg_words_m1,
  input logic [LW-1:0] wcnt,
  input logic          upd_valid,
  input logic          ack,
  input logic          req,
  input logic [AW-1:0] fetch_addr,
  input logic          eof,
  input logic          upd_pending
);
  p_req_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> !req);

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ack && cfg_en) |=> $stable(fetch_addr));

  p_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> (fetch_addr[1:0] == 2'b00));

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req && ack && cfg_en && wcnt != cfg_words_m1) |=> fetch_addr == $past(fetch_addr) + AW'(4));

  p_eof_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    eof |-> $past(req && ack && cfg_en));

  p_pend_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (eof && cfg_dual && !$past(upd_valid)) |-> !upd_pending);
endmodule

bind wfb_addr_gen wfb_addr_gen_chk #(.AW(AW), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_dual(cfg_dual),
  .cfg_words_m1(cfg_words_m1), .wcnt(wcnt), .upd_valid(upd_valid),
  .ack(ack), .req(req), .fetch_addr(fetch_addr), .eof(eof),
  .upd_pending(upd_pending)
);

// File: tb/wfb_addr_gen_tb.sv
`timescale 1ns/1ps
module wfb_addr_gen_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_en = 0, cfg_2d = 0, cfg_dual = 0;
  logic [4:0]  cfg_pix_off = '0;
  logic [15:0] cfg_skip = '0;
  logic [11:0] cfg_words_m1 = '0, cfg_lines_m1 = '0;
  logic base0_wr = 0, base1_wr = 0, upd_valid = 0, ack = 0;
  logic [31:0] base0_wdata = '0, base1_wdata = '0;
  logic req, line_start, panel, eof, upd_pending;
  logic [31:0] fetch_addr;
  logic [4:0]  line_off;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  wfb_addr_gen u_dut (.*);

  task automatic chk(input bit ok, input string r, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_addr(input logic [31:0] b, input int l, input int w);
    int stride = int'(cfg_words_m1) + 1 + (cfg_2d ? int'(cfg_skip) : 0);
    return b + 32'(4 * (l * stride + w));
  endfunction

  task automatic run_frame(input logic [31:0] b0, input logic [31:0] b1, input logic [31:0] nb,
                           input bit coll, input bit exp_pend);
    int np = cfg_dual ? 2 : 1;
    for (int p = 0; p < np; p++)
      for (int l = 0; l <= int'(cfg_lines_m1); l++)
        for (int w = 0; w <= int'(cfg_words_m1); w++) begin
          bit got = 0;
          bit last = (p == np-1) && (l == int'(cfg_lines_m1)) && (w == int'(cfg_words_m1));
          while (!got) begin
            @(negedge clk);
            ack = (($urandom % 4) != 0);
            if (req && ack) begin
              got = 1;
              chk(fetch_addr == exp_addr(p ? b1 : b0, l, w), (l == 0 && w > 0) ? "R3" : (cfg_2d ? "R4" : "R6"),
                  fetch_addr, exp_addr(p ? b1 : b0, l, w));
              chk(line_start == (w == 0), "R5 line_start", line_start, (w == 0));
              chk(line_off == (cfg_2d ? cfg_pix_off : 5'd0), "R5 line_off", line_off, cfg_2d ? cfg_pix_off : 5'd0);
              chk(panel == p[0], "R9 panel", panel, p);
              chk(!eof, "R7 no eof mid-frame", eof, 0);
              if (last && coll) begin
                base0_wr = 1; base0_wdata = 32'h4000;
                base1_wr = 1; base1_wdata = 32'h9000;
                upd_valid = 1;
              end
            end
          end
        end
    @(negedge clk);
    ack = 0; base0_wr = 0; base1_wr = 0; upd_valid = 0;
    chk(eof, "R7 eof pulse", eof, 1);
    chk(fetch_addr == nb, coll ? "R11 next base" : "R7 restart base", fetch_addr, nb);
    chk(upd_pending == exp_pend, coll ? "R11 pending kept" : "R10 pending", upd_pending, exp_pend);
    @(negedge clk);
    chk(!eof, "R7 eof single cycle", eof, 0);
  endtask

  task automatic pulse_wr0(input logic [31:0] d);
    @(negedge clk); base0_wr = 1; base0_wdata = d;
    @(negedge clk); base0_wr = 0;
  endtask

  task automatic pulse_wr1(input logic [31:0] d);
    @(negedge clk); base1_wr = 1; base1_wdata = d;
    @(negedge clk); base1_wr = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(!req && !eof && !upd_pending && fetch_addr == 0, "R1 reset state", {req, eof, upd_pending}, 0);
    rst_n = 1;
    cfg_2d = 1; cfg_words_m1 = 3; cfg_lines_m1 = 2; cfg_skip = 5; cfg_pix_off = 7;
    pulse_wr0(32'h1003);
    @(negedge clk);
    chk(!req, "R2 req low while disabled", req, 0);
    cfg_en = 1;
    @(negedge clk);
    chk(req && fetch_addr == 0, "R8 write not active before eof", fetch_addr, 0);
    run_frame(0, 0, 32'h1000, 0, 0);
    run_frame(32'h1000, 0, 32'h1000, 0, 0);
    cfg_2d = 0;
    run_frame(32'h1000, 0, 32'h1000, 0, 0);
    cfg_2d = 1;
    pulse_wr0(32'h2000);
    repeat (3) begin @(negedge clk); ack = 1; end
    @(negedge clk); ack = 0; cfg_en = 0;
    @(negedge clk);
    chk(!req, "R2 req drops", req, 0);
    chk(fetch_addr == 32'h1000, "R2 restart at active base", fetch_addr, 32'h1000);
    cfg_en = 1;
    @(negedge clk);
    chk(req, "R2 req returns", req, 1);
    run_frame(32'h1000, 0, 32'h2000, 0, 0);
    cfg_dual = 1;
    pulse_wr0(32'h3000);
    pulse_wr1(32'h8000);
    run_frame(32'h2000, 0, 32'h2000, 0, 0);
    @(negedge clk); upd_valid = 1;
    @(negedge clk); upd_valid = 0;
    chk(upd_pending, "R10 validate flag set", upd_pending, 1);
    run_frame(32'h2000, 0, 32'h3000, 0, 0);
    run_frame(32'h3000, 32'h8000, 32'h3000, 1, 1);
    run_frame(32'h3000, 32'h8000, 32'h4000, 0, 0);
    run_frame(32'h4000, 32'h9000, 32'h4000, 0, 0);
    cfg_dual = 0;
    for (int k = 0; k < 12; k++) begin
      cfg_en = 0;
      @(negedge clk);
      cfg_2d = 1'($urandom);
      cfg_words_m1 = 12'($urandom % 8);
      cfg_lines_m1 = 12'($urandom % 5);
      cfg_skip = 16'($urandom % 300);
      cfg_pix_off = 5'($urandom);
      cfg_en = 1;
      @(negedge clk);
      run_frame(32'h4000, 0, 32'h4000, 0, 0);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule